// File: doc/BRIEF.md
# External Status Change Interrupt Unit

This block watches three modem-control pins (clear-to-send, carrier detect, sync) and five line-status flags from neighbouring detectors. The flags are break, abort, end-of-poll, transmit underrun and a baud-rate-generator zero-count pulse. It raises one interrupt request when an enabled source changes. Each source has an enable bit. The line mode decides which of the three level-type flags count at all: break counts only in asynchronous mode, abort only in SDLC mode, and end-of-poll only in SDLC loop mode. The pins and the three level-type flags interrupt on a change in either direction. Underrun and zero-count interrupt only on their rising edge.

When an interrupt is raised, the status word freezes with the source levels of the cycle that caused it. It stays frozen until software issues a reset-status command, so a handler reads a consistent snapshot. The pins pass through a synchronizer. After reset, a warm-up window absorbs whatever levels the inputs already hold, so no false interrupt is raised.

The controller is a three-state machine:
- `ST_WARM`: warm-up after reset. The only transition is warm-done, which leads to `ST_WATCH` after SYNC_STAGES+1 clocks.
- `ST_WATCH`: status follows the live levels and the request is low. The transition on an enabled event leads to `ST_HELD`.
- `ST_HELD`: request high and status frozen. On reset-status with no event pending, the machine goes back to `ST_WATCH`. On reset-status in the same cycle as an event, it stays in `ST_HELD` and recaptures the status.

Top module: `ext_status_irq`

## Requirements
- R1: While `rst_n` is low, `irq_o` is 0 and `stat_o` is 0.
- R2: A change in either direction on `cts_i`, `dcd_i` or `sync_i` sets `irq_o` on the third rising clock edge after the change and not before. The status bit order is: 0 cts, 1 dcd, 2 sync, 3 break, 4 abort, 5 end-of-poll, 6 underrun, 7 zero-count.
- R3: A rising edge on `txund_i` or `brgz_i` sets `irq_o` on the second rising edge after it. A falling edge on either has no effect. A one-cycle pulse on `brgz_i` is captured as `stat_o[7]`=1.
- R4: `brk_i` is a valid source only when `mode_i` = 2'b00 (asynchronous). In any other mode it never raises `irq_o`, although `stat_o[3]` still shows its level.
- R5: `abort_i` is a valid source only when `mode_i` = 2'b01 (SDLC). In that mode both its start and its end raise `irq_o`.
- R6: `eop_i` is a valid source only when `mode_i` = 2'b10 (SDLC loop). In that mode both its start and its end raise `irq_o`.
- R7: In asynchronous mode, both the start and the end of a break raise `irq_o`.
- R8: A source whose bit in `en_i` is 0 never raises `irq_o`. The bit positions match those of `stat_o`.
- R9: While `irq_o` is high and `clr_i` is low, `stat_o` holds the levels captured in the cycle that raised the interrupt. While `irq_o` is low, `stat_o` follows the input levels.
- R10: A one-cycle `clr_i` pulse drops `irq_o` at the next edge and reloads `stat_o` with the live levels. A change that occurred while the request was held does not raise it again. The next enabled change after the clear does raise it.
- R11: If an enabled event is pending in the same cycle as `clr_i`, `irq_o` stays high and `stat_o` recaptures the live levels.
- R12: Levels that the inputs already hold when reset is released raise no interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cts_i | input | 1 | Clear-to-send pin, asynchronous |
| dcd_i | input | 1 | Carrier-detect pin, asynchronous |
| sync_i | input | 1 | Sync pin, asynchronous |
| brk_i | input | 1 | Break-detected level |
| abort_i | input | 1 | Abort-detected level |
| eop_i | input | 1 | End-of-poll level |
| txund_i | input | 1 | Transmit-underrun flag |
| brgz_i | input | 1 | Baud-rate-generator zero-count pulse |
| mode_i | input | 2 | 00 async, 01 SDLC, 10 SDLC loop, 11 none |
| en_i | input | 8 | Per-source enable, same bit order as status |
| clr_i | input | 1 | Reset-status command |
| irq_o | output | 1 | Interrupt request |
| stat_o | output | 8 | Status levels, frozen while request is high |

## Verification
A machine stuck in `ST_WARM` or `ST_WATCH` shows up as `irq_o` staying low two or three edges after an enabled change, where a rise is expected. A machine stuck in `ST_HELD` shows up as `irq_o` still high one edge after a clear. A broken capture path shows up as `stat_o` moving while the request is high, or showing stale bits right after the clear. Mode or enable qualification that is wrong shows up within two edges as a request from a source that should be ignored.

// File: rtl/estat_pkg.sv
package estat_pkg;

    typedef enum logic [1:0] {
        MODE_ASYNC = 2'b00,
        MODE_SDLC  = 2'b01,
        MODE_LOOP  = 2'b10,
        MODE_NONE  = 2'b11
    } line_mode_e;

    typedef enum logic [1:0] {
        ST_WARM  = 2'b00,
        ST_WATCH = 2'b01,
        ST_HELD  = 2'b10
    } ctl_state_e;

    localparam int NSRC     = 8;
    localparam int NPIN     = 3;
    localparam int NFLAG    = NSRC - NPIN;
    localparam int SRC_CTS  = 0;
    localparam int SRC_DCD  = 1;
    localparam int SRC_SYNC = 2;
    localparam int SRC_BRK  = 3;
    localparam int SRC_ABT  = 4;
    localparam int SRC_EOP  = 5;
    localparam int SRC_UND  = 6;
    localparam int SRC_BRGZ = 7;

    // sources that raise on both edges (pins and level-type flags)
    localparam logic [NSRC-1:0] BOTH_EDGE = 8'b0011_1111;

    function automatic logic [NSRC-1:0] mode_valid(input line_mode_e m);
        logic [NSRC-1:0] v;
        v = '1;
        v[SRC_BRK] = (m == MODE_ASYNC);
        v[SRC_ABT] = (m == MODE_SDLC);
        v[SRC_EOP] = (m == MODE_LOOP);
        return v;
    endfunction

endpackage

// File: rtl/estat_sync.sv
module estat_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] chain_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[0] <= '0;
        else        chain_q[0] <= d_i;
    end

    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[g] <= '0;
                else        chain_q[g] <= chain_q[g-1];
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/estat_edge.sv
module estat_edge
    import estat_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_i,
    input  line_mode_e   mode_i,
    input  logic [N-1:0] en_i,
    output logic [N-1:0] evt_o
);
    logic [N-1:0] prev_q;
    logic [N-1:0] valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl_i;
    end

    always_comb valid = mode_valid(mode_i);

    generate
        for (genvar i = 0; i < N; i++) begin : g_src
            if (BOTH_EDGE[i]) begin : g_both
                assign evt_o[i] = en_i[i] & valid[i] & (lvl_i[i] ^ prev_q[i]);
            end else begin : g_rise
                assign evt_o[i] = en_i[i] & valid[i] & lvl_i[i] & ~prev_q[i];
            end
        end
    endgenerate
endmodule

// File: rtl/estat_ctrl.sv
module estat_ctrl
    import estat_pkg::*;
#(
    parameter int N           = NSRC,
    parameter int WARM_CYCLES = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_i,
    input  logic [N-1:0] live_i,
    input  logic         clr_i,
    output logic         irq_o,
    output logic [N-1:0] stat_o
);
    localparam int CW = $clog2(WARM_CYCLES + 1);

    ctl_state_e    state_q, state_d;
    logic [CW-1:0] warm_q;
    logic          warm_done;
    logic          evt_any;
    logic [N-1:0]  stat_q;

    assign evt_any   = |evt_i;
    assign warm_done = (warm_q == CW'(WARM_CYCLES - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WARM;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   warm_q <= '0;
        else if (state_q == ST_WARM)  warm_q <= warm_q + CW'(1);
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WARM:  if (warm_done) state_d = ST_WATCH;
            ST_WATCH: if (evt_any)   state_d = ST_HELD;
            ST_HELD:  if (clr_i)     state_d = evt_any ? ST_HELD : ST_WATCH;
            default:                 state_d = ST_WARM;
        endcase
    end

    // status capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               stat_q <= '0;
        else if (!(state_q == ST_HELD && !clr_i)) stat_q <= live_i;
    end

    // outputs
    always_comb begin
        irq_o  = (state_q == ST_HELD);
        stat_o = stat_q;
    end

    assert_hold_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !clr_i) |=> irq_o);
    assert_stat_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !clr_i) |=> $stable(stat_o));
    assert_clear_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && clr_i && !evt_any) |=> !irq_o);
    assert_coincide_keeps_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && clr_i && evt_any) |=> irq_o);
    assert_rise_needs_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_o && !evt_any) |=> !irq_o);
endmodule

// File: rtl/ext_status_irq.sv
module ext_status_irq
    import estat_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cts_i,
    input  logic       dcd_i,
    input  logic       sync_i,
    input  logic       brk_i,
    input  logic       abort_i,
    input  logic       eop_i,
    input  logic       txund_i,
    input  logic       brgz_i,
    input  logic [1:0] mode_i,
    input  logic [7:0] en_i,
    input  logic       clr_i,
    output logic       irq_o,
    output logic [7:0] stat_o
);
    localparam int WARM = SYNC_STAGES + 1;

    logic [NPIN-1:0]  pins_q;
    logic [NFLAG-1:0] flags_q;
    logic [NSRC-1:0]  lvl;
    logic [NSRC-1:0]  evt;
    line_mode_e       mode;

    assign mode = line_mode_e'(mode_i);

    estat_sync #(.WIDTH(NPIN), .STAGES(SYNC_STAGES)) u_pin_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  ({sync_i, dcd_i, cts_i}),
        .q_o  (pins_q)
    );

    estat_sync #(.WIDTH(NFLAG), .STAGES(1)) u_flag_reg (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  ({brgz_i, txund_i, eop_i, abort_i, brk_i}),
        .q_o  (flags_q)
    );

    assign lvl = {flags_q, pins_q};

    estat_edge #(.N(NSRC)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_i (lvl),
        .mode_i(mode),
        .en_i  (en_i),
        .evt_o (evt)
    );

    estat_ctrl #(.N(NSRC), .WARM_CYCLES(WARM)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .evt_i (evt),
        .live_i(lvl),
        .clr_i (clr_i),
        .irq_o (irq_o),
        .stat_o(stat_o)
    );

    assert_rise_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(|en_i));
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |-> (!irq_o && stat_o == '0));
endmodule

// File: tb/tb_ext_status_irq.sv
module tb_ext_status_irq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cts_i = 1'b0, dcd_i = 1'b0, sync_i = 1'b0;
    logic       brk_i = 1'b0, abort_i = 1'b0, eop_i = 1'b0;
    logic       txund_i = 1'b0, brgz_i = 1'b0;
    logic [1:0] mode_i = 2'b00;
    logic [7:0] en_i = 8'hFF;
    logic       clr_i = 1'b0;
    logic       irq_o;
    logic [7:0] stat_o;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    ext_status_irq dut (
        .clk(clk), .rst_n(rst_n), .cts_i(cts_i), .dcd_i(dcd_i), .sync_i(sync_i),
        .brk_i(brk_i), .abort_i(abort_i), .eop_i(eop_i), .txund_i(txund_i),
        .brgz_i(brgz_i), .mode_i(mode_i), .en_i(en_i), .clr_i(clr_i),
        .irq_o(irq_o), .stat_o(stat_o)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic clear_irq();
        clr_i = 1'b1;
        tick(1);
        clr_i = 1'b0;
    endtask

    task automatic set_src(input int idx, input logic v);
        case (idx)
            0: cts_i = v;   1: dcd_i = v;   2: sync_i = v;   3: brk_i = v;
            4: abort_i = v; 5: eop_i = v;   6: txund_i = v;  default: brgz_i = v;
        endcase
    endtask

    task automatic t_reset();
        cts_i = 1'b1;
        tick(4);
        check("R1", "irq in reset", {7'd0, irq_o}, 8'h00);
        check("R1", "stat in reset", stat_o, 8'h00);
        rst_n = 1'b1;
        tick(8);
        check("R12", "no irq from held level", {7'd0, irq_o}, 8'h00);
        check("R12", "stat follows live", stat_o, 8'h01);
        cts_i = 1'b0;
        tick(3);
        check("R2", "cts fall irq", {7'd0, irq_o}, 8'h01);
        clear_irq();
        tick(2);
    endtask

    task automatic t_pin(input int idx);
        set_src(idx, 1'b1);
        tick(2);
        check("R2", "pin rise not yet", {7'd0, irq_o}, 8'h00);
        tick(1);
        check("R2", "pin rise irq", {7'd0, irq_o}, 8'h01);
        check("R2", "pin rise stat", stat_o, 8'(1 << idx));
        clear_irq();
        check("R10", "clear drops irq", {7'd0, irq_o}, 8'h00);
        set_src(idx, 1'b0);
        tick(3);
        check("R2", "pin fall irq", {7'd0, irq_o}, 8'h01);
        check("R2", "pin fall stat", stat_o, 8'h00);
        clear_irq();
        tick(2);
    endtask

    task automatic t_flags();
        txund_i = 1'b1;
        tick(1);
        check("R3", "underrun not yet", {7'd0, irq_o}, 8'h00);
        tick(1);
        check("R3", "underrun irq", {7'd0, irq_o}, 8'h01);
        check("R3", "underrun stat", stat_o, 8'h40);
        clear_irq();
        txund_i = 1'b0;
        tick(5);
        check("R3", "underrun fall ignored", {7'd0, irq_o}, 8'h00);
        brgz_i = 1'b1;
        tick(1);
        brgz_i = 1'b0;
        check("R3", "zero-count not yet", {7'd0, irq_o}, 8'h00);
        tick(1);
        check("R3", "zero-count irq", {7'd0, irq_o}, 8'h01);
        check("R3", "zero-count captured", stat_o, 8'h80);
        clear_irq();
        tick(4);
        check("R3", "zero-count fall ignored", {7'd0, irq_o}, 8'h00);
    endtask

    // level flag valid in mode 'ok', ignored in mode 'bad'
    task automatic t_level(input int idx, input logic [1:0] ok, input logic [1:0] bad,
                           input string req);
        mode_i = ok;
        tick(2);
        set_src(idx, 1'b1);
        tick(2);
        check(req, "level start irq", {7'd0, irq_o}, 8'h01);
        clear_irq();
        set_src(idx, 1'b0);
        tick(2);
        check(req, "level end irq", {7'd0, irq_o}, 8'h01);
        clear_irq();
        mode_i = bad;
        tick(2);
        set_src(idx, 1'b1);
        tick(5);
        check(req, "wrong mode ignored", {7'd0, irq_o}, 8'h00);
        check(req, "wrong mode stat live", stat_o, 8'(1 << idx));
        set_src(idx, 1'b0);
        tick(5);
        check(req, "wrong mode end ignored", {7'd0, irq_o}, 8'h00);
        mode_i = 2'b00;
        tick(2);
    endtask

    task automatic t_enable();
        en_i = 8'hFD;
        dcd_i = 1'b1;
        tick(5);
        check("R8", "disabled dcd rise", {7'd0, irq_o}, 8'h00);
        check("R8", "disabled dcd stat", stat_o, 8'h02);
        dcd_i = 1'b0;
        tick(5);
        check("R8", "disabled dcd fall", {7'd0, irq_o}, 8'h00);
        en_i = 8'h7F;
        brgz_i = 1'b1;
        tick(1);
        brgz_i = 1'b0;
        tick(4);
        check("R8", "disabled zero-count", {7'd0, irq_o}, 8'h00);
        en_i = 8'hFF;
        tick(2);
        check("R8", "re-enable no event", {7'd0, irq_o}, 8'h00);
    endtask

    task automatic t_latch();
        cts_i = 1'b1;
        tick(3);
        check("R9", "latch irq", {7'd0, irq_o}, 8'h01);
        check("R9", "latch stat", stat_o, 8'h01);
        cts_i = 1'b0;
        dcd_i = 1'b1;
        tick(5);
        check("R9", "stat frozen", stat_o, 8'h01);
        check("R9", "irq held", {7'd0, irq_o}, 8'h01);
        clear_irq();
        check("R10", "clear drops irq", {7'd0, irq_o}, 8'h00);
        check("R10", "clear reloads live", stat_o, 8'h02);
        tick(4);
        check("R10", "held change not replayed", {7'd0, irq_o}, 8'h00);
        dcd_i = 1'b0;
        tick(3);
        check("R10", "next change re-asserts", {7'd0, irq_o}, 8'h01);
        clear_irq();
        tick(2);
    endtask

    task automatic t_coincide();
        cts_i = 1'b1;
        tick(3);
        txund_i = 1'b1;
        tick(1);
        clr_i = 1'b1;
        tick(1);
        clr_i = 1'b0;
        check("R11", "irq kept", {7'd0, irq_o}, 8'h01);
        check("R11", "stat recaptured", stat_o, 8'h41);
        clear_irq();
        check("R11", "second clear drops", {7'd0, irq_o}, 8'h00);
        txund_i = 1'b0;
        cts_i = 1'b0;
        tick(3);
        clear_irq();
        tick(3);
        check("R11", "quiet after cleanup", {7'd0, irq_o}, 8'h00);
    endtask

    initial begin
        t_reset();
        for (int i = 0; i < 3; i++) t_pin(i);
        t_flags();
        t_level(3, 2'b00, 2'b01, "R4");
        t_level(3, 2'b00, 2'b10, "R7");
        t_level(4, 2'b01, 2'b00, "R5");
        t_level(5, 2'b10, 2'b01, "R6");
        t_enable();
        t_latch();
        t_coincide();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule